// File: doc/BRIEF.md
# Fault-Detecting Split-Round AES-128 Encryptor

This block encrypts one 128-bit block with AES-128. It also watches for transient faults while it runs. Each cipher round is cut into two half-round units with a pipeline register between them. The first unit performs byte substitution and then the row rotation. The second unit performs column mixing and then the round-key XOR. In the final round the second unit skips column mixing.

Every half-round result is produced twice from the same stored input: once to advance the cipher and once to check it. The two half units swap these roles on alternate cycles, so a round costs two clocks and no datapath logic is duplicated.

The block does not expand the key. It drives a round-index output, and the surrounding logic returns the matching 128-bit round key on the same cycle without a register. A mismatch between a result and its recomputation does three things:
- it pulses the fault flag for that half;
- it sets a sticky error bit;
- it marks the ciphertext of that run as untrustworthy.

Two test-only XOR masks can corrupt either half-round output in any chosen cycle.

Top module: `aesfd_top`

## Requirements
- R1: After reset, `done`, `fault_h1`, `fault_h2` and `err` are 0 and `key_idx` is 0.
- R2: In the n-th cycle after the accepted start edge (n = 1..2·NR+1), `key_idx` equals n/2 rounded down. The start edge itself loads `plain` XOR the key returned for index 0.
- R3: With both masks zero, `ct` equals the standard AES-128 result, for example key 000102..0f with plaintext 00112233..ff giving 69c4e0d86a7b0430d8cdb78070b4c55a. `done` rises exactly 2·NR+1 clock edges after the start edge.
- R4: `done` is high for exactly one cycle per run.
- R5: The first half applies the S-box to each byte and then shifts row r of the column-major state left by r bytes. Byte 0 sits in bits 127:120. The second half mixes columns and XORs the round key, and the final round bypasses column mixing.
- R6: A nonzero `inj_h1` mask in a cycle where the first half advances the cipher (cycle 2r-1) gives one `fault_h1` pulse and no `fault_h2` pulse. It also leaves `err`=1 at `done` and a wrong `ct`.
- R7: A nonzero `inj_h2` mask in a cycle where the second half advances the cipher (cycle 2r) gives one `fault_h2` pulse and no `fault_h1` pulse. It also leaves `err`=1 at `done` and a wrong `ct`.
- R8: A mask applied in a half's recomputation cycle raises that half's flag once and sets `err`, while `ct` stays correct. The first half recomputes in cycle 2r. The second half recomputes in cycle 2r+1, with cycle 2·NR+1 for the last round.
- R9: A mask has no effect when the masked half neither advances nor is checked in that cycle: `inj_h2` in cycle 1, or `inj_h1` in cycle 2·NR+1. In that case no flag rises, `err` stays 0 and `ct` is correct.
- R10: `err` stays 1 after a mismatch, including while idle, until the next accepted start clears it.
- R11: `start` and `plain` are ignored while a run is in progress. The running encryption keeps its timing and its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin an encryption when idle |
| plain | input | 128 | Plaintext block, sampled on the accepted start edge |
| key_idx | output | $clog2(NR+1) | Index of the round key wanted this cycle |
| rk_in | input | 128 | Round key for `key_idx`, returned in the same cycle |
| inj_h1 | input | 128 | Test XOR mask on the first half-round output |
| inj_h2 | input | 128 | Test XOR mask on the second half-round output |
| ct | output | 128 | Ciphertext / current round state |
| done | output | 1 | One-cycle pulse after the last check completes |
| fault_h1 | output | 1 | First-half recomputation mismatched in the previous cycle |
| fault_h2 | output | 1 | Second-half recomputation mismatched in the previous cycle |
| err | output | 1 | Sticky mismatch indicator for the current run |

## Verification
The hard case is a fault that strikes exactly one half-round in exactly one cycle. It must be told apart by role: the advancing result versus the check result. It must also be told apart from cycles where the masked output is simply unused. No natural stimulus produces this. The bench therefore counts cycles from the start edge and drives a one-cycle mask into a chosen cycle. It then checks which flag pulses, whether the ciphertext is damaged, and that masks in the unused slots stay silent.

// File: rtl/aesfd_pkg.sv
package aesfd_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FIRST  = 2'd1,
    PH_SECOND = 2'd2,
    PH_TAIL   = 2'd3
  } phase_e;

  function automatic logic [7:0] gf_dbl(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] cur;
    acc = 8'h00;
    cur = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ cur;
      cur = gf_dbl(cur);
    end
    return acc;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] b, input int n);
    return (b << n) | (b >> (8 - n));
  endfunction

  // Multiplicative inverse as x^254, then the affine map.
  function automatic logic [7:0] sbox_calc(input logic [7:0] x);
    logic [7:0] r;
    r = x;
    for (int i = 0; i < 6; i++) r = gf_mul(gf_mul(r, r), x);
    r = gf_mul(r, r);
    return r ^ rotl8(r, 1) ^ rotl8(r, 2) ^ rotl8(r, 3) ^ rotl8(r, 4) ^ 8'h63;
  endfunction

endpackage

// File: rtl/aesfd_sbox.sv
module aesfd_sbox (
  input  logic [7:0] din,
  output logic [7:0] dout
);
  import aesfd_pkg::*;

  always_comb dout = sbox_calc(din);

endmodule

// File: rtl/aesfd_subshift.sv
module aesfd_subshift #(
  parameter int NCOL = 4
) (
  input  logic [32*NCOL-1:0] din,
  output logic [32*NCOL-1:0] dout
);
  localparam int NBYTE = 4 * NCOL;
  localparam int W     = 8 * NBYTE;

  logic [W-1:0] sub;

  for (genvar k = 0; k < NBYTE; k++) begin : g_sb
    aesfd_sbox u_sb (
      .din  (din[W-8-8*k +: 8]),
      .dout (sub[W-8-8*k +: 8])
    );
  end

  // Row r of the column-major state rotates left by r byte positions.
  for (genvar c = 0; c < NCOL; c++) begin : g_col
    for (genvar r = 0; r < 4; r++) begin : g_row
      assign dout[W-8-8*(4*c+r) +: 8] = sub[W-8-8*(4*((c+r)%NCOL)+r) +: 8];
    end
  end

endmodule

// File: rtl/aesfd_mixark.sv
module aesfd_mixark #(
  parameter int NCOL = 4
) (
  input  logic [32*NCOL-1:0] din,
  input  logic [32*NCOL-1:0] rk,
  input  logic               skip_mix,
  output logic [32*NCOL-1:0] dout
);
  import aesfd_pkg::*;

  localparam int W = 32 * NCOL;

  logic [W-1:0] mixed;

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    logic [7:0] b [4];
    for (genvar r = 0; r < 4; r++) begin : g_in
      assign b[r] = din[W-8-8*(4*c+r) +: 8];
    end
    // One doubling per output byte: 2(b_i ^ b_i+1) ^ b_i+1 ^ b_i+2 ^ b_i+3.
    for (genvar r = 0; r < 4; r++) begin : g_out
      assign mixed[W-8-8*(4*c+r) +: 8] =
          gf_dbl(b[r] ^ b[(r+1)%4]) ^ b[(r+1)%4] ^ b[(r+2)%4] ^ b[(r+3)%4];
    end
  end

  always_comb dout = (skip_mix ? din : mixed) ^ rk;

endmodule

// File: rtl/aesfd_top.sv
module aesfd_top #(
  parameter int NR = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [127:0]             plain,
  output logic [$clog2(NR+1)-1:0]  key_idx,
  input  logic [127:0]             rk_in,
  input  logic [127:0]             inj_h1,
  input  logic [127:0]             inj_h2,
  output logic [127:0]             ct,
  output logic                     done,
  output logic                     fault_h1,
  output logic                     fault_h2,
  output logic                     err
);
  import aesfd_pkg::*;

  localparam int KW = $clog2(NR + 1);

  // Reset release synchronizer
  logic rs0_q, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs0_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rs0_q <= 1'b1;
      rst_q <= rs0_q;
    end
  end

  phase_e       st_q, st_d;
  logic [KW-1:0] rnd_q, rnd_d;
  logic [127:0] s_q, s_d, p_q, p_d;
  logic         s_en, p_en;
  logic         f1_q, f2_q, err_q, done_q;
  logic         err_d, done_d, err_clr;
  logic         mis1, mis2, last_rnd;
  logic [127:0] h1_raw, h2_raw, h1_out, h2_out;

  assign last_rnd = (rnd_q == KW'(NR));

  aesfd_subshift #(.NCOL(4)) u_half1 (
    .din  (s_q),
    .dout (h1_raw)
  );

  aesfd_mixark #(.NCOL(4)) u_half2 (
    .din      (p_q),
    .rk       (rk_in),
    .skip_mix (last_rnd),
    .dout     (h2_raw)
  );

  assign h1_out = h1_raw ^ inj_h1;
  assign h2_out = h2_raw ^ inj_h2;

  // Next-state logic
  always_comb begin
    st_d    = st_q;
    rnd_d   = rnd_q;
    s_en    = 1'b0;
    s_d     = h2_out;
    p_en    = 1'b0;
    p_d     = h1_out;
    mis1    = 1'b0;
    mis2    = 1'b0;
    done_d  = 1'b0;
    err_clr = 1'b0;
    case (st_q)
      PH_IDLE: begin
        rnd_d = '0;
        if (start) begin
          s_en    = 1'b1;
          s_d     = plain ^ rk_in;
          st_d    = PH_FIRST;
          err_clr = 1'b1;
        end
      end
      PH_FIRST: begin
        // half 1 advances; half 2 re-derives the previous round output
        p_en  = 1'b1;
        mis2  = (rnd_q != '0) && (h2_out != s_q);
        st_d  = PH_SECOND;
        rnd_d = rnd_q + 1'b1;
      end
      PH_SECOND: begin
        // half 2 advances; half 1 re-derives the pipeline register
        s_en = 1'b1;
        mis1 = (h1_out != p_q);
        st_d = last_rnd ? PH_TAIL : PH_FIRST;
      end
      PH_TAIL: begin
        mis2   = (h2_out != s_q);
        st_d   = PH_IDLE;
        rnd_d  = '0;
        done_d = 1'b1;
      end
      default: st_d = PH_IDLE;
    endcase
    err_d = err_clr ? 1'b0 : (err_q | mis1 | mis2);
  end

  // Registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      st_q   <= PH_IDLE;
      rnd_q  <= '0;
      f1_q   <= 1'b0;
      f2_q   <= 1'b0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      rnd_q  <= rnd_d;
      f1_q   <= mis1;
      f2_q   <= mis2;
      err_q  <= err_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      s_q <= '0;
      p_q <= '0;
    end else begin
      if (s_en) s_q <= s_d;
      if (p_en) p_q <= p_d;
    end
  end

  assign key_idx  = rnd_q;
  assign ct       = s_q;
  assign done     = done_q;
  assign fault_h1 = f1_q;
  assign fault_h2 = f2_q;
  assign err      = err_q;

  // Assertions
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_q)
    done |=> !done);

  p_err_hold_r10: assert property (@(posedge clk) disable iff (!rst_q)
    (err && !(st_q == PH_IDLE && start)) |=> err);

  p_kidx_range_r2: assert property (@(posedge clk) disable iff (!rst_q)
    key_idx <= KW'(NR));

  p_kidx_step_r2: assert property (@(posedge clk) disable iff (!rst_q)
    (key_idx == $past(key_idx)) || (key_idx == $past(key_idx) + 1'b1) || (key_idx == '0));

  p_f1_source_r6: assert property (@(posedge clk) disable iff (!rst_q)
    fault_h1 |-> ($past(st_q) == PH_SECOND));

  p_f2_source_r7: assert property (@(posedge clk) disable iff (!rst_q)
    fault_h2 |-> ($past(st_q) == PH_FIRST || $past(st_q) == PH_TAIL));

  p_busy_start_r11: assert property (@(posedge clk) disable iff (!rst_q)
    (st_q == PH_FIRST && start) |=> (st_q == PH_SECOND));

  p_flag_sets_err_r8: assert property (@(posedge clk) disable iff (!rst_q)
    (fault_h1 || fault_h2) |-> err);

endmodule

// File: tb/aesfd_top_tb.sv
`timescale 1ns/1ps
module aesfd_top_tb;

  localparam int NR  = 10;
  localparam int LAT = 2 * NR + 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [127:0] plain = '0;
  logic [3:0]   key_idx;
  logic [127:0] rk_in;
  logic [127:0] inj_h1 = '0;
  logic [127:0] inj_h2 = '0;
  logic [127:0] ct;
  logic         done, fault_h1, fault_h2, err;

  always #2 clk = ~clk;  // 250 MHz

  aesfd_top #(.NR(NR)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .plain(plain),
    .key_idx(key_idx), .rk_in(rk_in), .inj_h1(inj_h1), .inj_h2(inj_h2),
    .ct(ct), .done(done), .fault_h1(fault_h1), .fault_h2(fault_h2), .err(err)
  );

  int n_tests = 0;
  int n_fail  = 0;

  // Independent reference: S-box by exhaustive inverse search
  function automatic logic [7:0] m2(input logic [7:0] a);
    return a[7] ? ((a << 1) ^ 8'h1b) : (a << 1);
  endfunction
  function automatic logic [7:0] mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 0;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p ^= a;
      a = m2(a);
    end
    return p;
  endfunction
  function automatic logic [7:0] sref(input logic [7:0] x);
    logic [7:0] inv = 0;
    logic [7:0] y;
    for (int c = 1; c < 256; c++) if (mul(x, 8'(c)) == 8'h01) inv = 8'(c);
    y = inv;
    for (int k = 1; k <= 4; k++) y ^= (inv << k) | (inv >> (8 - k));
    return y ^ 8'h63;
  endfunction

  logic [127:0] rks [0:NR];
  always_comb rk_in = rks[key_idx];

  task automatic expand(input logic [127:0] key);
    logic [31:0] w [0:4*NR+3];
    logic [31:0] t;
    logic [7:0]  rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
    for (int i = 4; i < 4*NR+4; i++) begin
      t = w[i-1];
      if (i % 4 == 0) begin
        t = {sref(t[23:16]), sref(t[15:8]), sref(t[7:0]), sref(t[31:24])} ^ {rc, 24'h0};
        rc = m2(rc);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int r = 0; r <= NR; r++) rks[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
  endtask

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Run results
  logic [127:0] r_ct;
  int r_lat, r_f1, r_f2, r_kbad;
  logic r_err, r_done_after;

  task automatic run(input logic [127:0] key, input logic [127:0] pt,
                     input int i1c, input logic [127:0] i1m,
                     input int i2c, input logic [127:0] i2m, input int sc);
    expand(key);
    r_lat = -1; r_f1 = 0; r_f2 = 0; r_kbad = 0; r_err = 1'b0; r_done_after = 1'b0; r_ct = '0;
    @(negedge clk);
    plain = pt;
    start = 1'b1;
    for (int n = 1; n <= 40; n++) begin
      @(negedge clk);
      if (fault_h1) r_f1++;
      if (fault_h2) r_f2++;
      if (n <= LAT && key_idx != 4'(n / 2)) r_kbad++;
      start  = (n == sc);
      plain  = (n == sc) ? ~pt : pt;
      inj_h1 = (n == i1c) ? i1m : '0;
      inj_h2 = (n == i2c) ? i2m : '0;
      if (done) begin
        r_lat = n - 1;
        r_ct  = ct;
        r_err = err;
        start = 1'b0; inj_h1 = '0; inj_h2 = '0;
        @(negedge clk);
        r_done_after = done;
        break;
      end
    end
    start = 1'b0; inj_h1 = '0; inj_h2 = '0;
  endtask

  localparam logic [383:0] VEC [3] = '{
    {128'h000102030405060708090a0b0c0d0e0f, 128'h00112233445566778899aabbccddeeff,
     128'h69c4e0d86a7b0430d8cdb78070b4c55a},
    {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h3243f6a8885a308d313198a2e0370734,
     128'h3925841d02dc09fbdc118597196a0b32},
    {128'h0, 128'h0, 128'h66e94bd4ef8a2c3b884cfa59ca342b2e}
  };

  logic [127:0] K0, P0, C0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(done == 0 && fault_h1 == 0 && fault_h2 == 0 && err == 0, "R1 reset flags",
        {124'h0, done, fault_h1, fault_h2, err}, 128'h0);
    chk(key_idx == 0, "R1 reset key_idx", 128'(key_idx), 128'h0);

    // Known-answer table walk: R3 R5 R4 R2
    for (int v = 0; v < 3; v++) begin
      run(VEC[v][383:256], VEC[v][255:128], 0, '0, 0, '0, 0);
      chk(r_ct == VEC[v][127:0], "R3/R5 ciphertext", r_ct, VEC[v][127:0]);
      chk(r_lat == LAT, "R3 latency", 128'(r_lat), 128'(LAT));
      chk(r_f1 == 0 && r_f2 == 0 && r_err == 0, "R3 clean run flags",
          128'({r_f1, r_f2}), 128'h0);
      chk(r_done_after == 0, "R4 done single cycle", 128'(r_done_after), 128'h0);
      chk(r_kbad == 0, "R2 key index sequence", 128'(r_kbad), 128'h0);
    end

    K0 = VEC[0][383:256]; P0 = VEC[0][255:128]; C0 = VEC[0][127:0];

    // R6: first half corrupted while advancing (round 3, cycle 5)
    run(K0, P0, 5, 128'h1 << 77, 0, '0, 0);
    chk(r_f1 == 1 && r_f2 == 0, "R6 flag pattern", 128'({r_f1, r_f2}), 128'({32'd1, 32'd0}));
    chk(r_err == 1 && r_ct != C0, "R6 err and bad ct", r_ct, C0);

    // R10: error persists while idle
    repeat (3) @(negedge clk);
    chk(err == 1, "R10 err sticky in idle", 128'(err), 128'h1);

    // R7: second half corrupted while advancing (round 4, cycle 8)
    run(K0, P0, 0, '0, 8, 128'h1 << 3, 0);
    chk(r_f2 == 1 && r_f1 == 0, "R7 flag pattern", 128'({r_f1, r_f2}), 128'({32'd0, 32'd1}));
    chk(r_err == 1 && r_ct != C0, "R7 err and bad ct", r_ct, C0);

    // R8: masks on recomputation cycles only
    run(K0, P0, 6, 128'hff << 40, 0, '0, 0);
    chk(r_f1 == 1 && r_f2 == 0 && r_err == 1, "R8 half1 recompute flag",
        128'({r_f1, r_f2}), 128'({32'd1, 32'd0}));
    chk(r_ct == C0, "R8 half1 recompute ct intact", r_ct, C0);
    run(K0, P0, 0, '0, LAT, 128'h1 << 127, 0);
    chk(r_f2 == 1 && r_f1 == 0 && r_err == 1, "R8 final half2 recompute flag",
        128'({r_f1, r_f2}), 128'({32'd0, 32'd1}));
    chk(r_ct == C0, "R8 final recompute ct intact", r_ct, C0);

    // R9: masks in unused slots
    run(K0, P0, LAT, 128'h5a << 64, 1, 128'ha5 << 8, 0);
    chk(r_f1 == 0 && r_f2 == 0 && r_err == 0, "R9 no flags",
        128'({r_f1, r_f2}), 128'h0);
    chk(r_ct == C0, "R9 ct intact", r_ct, C0);

    // R10: clean run after a faulty one clears err
    chk(r_err == 0, "R10 err cleared by new start", 128'(r_err), 128'h0);

    // R11: start with different plaintext mid-run is ignored
    run(K0, P0, 0, '0, 0, '0, 7);
    chk(r_lat == LAT, "R11 latency kept", 128'(r_lat), 128'(LAT));
    chk(r_ct == C0, "R11 result kept", r_ct, C0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule